// File: doc/BRIEF.md
# GPIO Port Data Register

This block is the data path of a 32-pin general-purpose I/O port. It sits behind a simple single-cycle register bus. Each pin has an output latch. Software can change the latch by writing the data register directly. It can also use separate set, clear and toggle registers, which change selected bits without a read-modify-write sequence.

A pin is driven from its latch only while two conditions hold: its function-select bit picks the general-purpose function, and its direction bit marks it as an output. A write always lands in the latch, even when the pin is not a driven output. The stored level appears on the pin as soon as the pin becomes one.

A read of the data register never returns the latch. It returns the pin level after a two-stage input synchronizer, and it does so whatever the pin's function or direction.

Top module: `gpio_data_port`

## Requirements
- R1: While reset is held, every latch bit, direction bit and function-select bit is 0, so `pin_out` and `pin_oe` are all zero and the direction and select registers read 0.
- R2: A bus write (`bus_sel`=1, `bus_we`=1) to word offset 0 loads `bus_wdata` into the latch, and `pin_out` shows it from the next clock edge on.
- R3: Bit n of `pin_oe` is 1 exactly when direction bit n is 1 (output) and function-select bit n is 0 (general-purpose).
- R4: A data write to a pin that is not a driven output is still stored. The stored level is presented with `pin_oe` set once the configuration makes the pin an output.
- R5: A write to offset 1 sets every latch bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R6: A write to offset 2 clears every latch bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R7: A write to offset 3 inverts every latch bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R8: A read (`bus_sel`=1, `bus_we`=0) of offset 0 returns `pin_in` as it was two clock edges earlier, independent of the latch, direction and select.
- R9: Reads of offsets 1, 2 and 3, of the unmapped offsets 6 and 7, and any cycle without a read return 0. Writes to offsets 6 and 7 change nothing.
- R10: Offset 4 (direction, 1 = output) and offset 5 (function select, 0 = general-purpose) store what is written and read it back.
- R11: The latch holds its value in every cycle without a write to offsets 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Pad output levels (the latch) |
| pin_oe | output | 32 | Pad output enables |

## Verification
The bench builds the block with its defaults: 32 pins and two synchronizer stages. At these values the whole 32-bit port is covered by each vector. Mixed patterns then exercise the gating of the output enable by direction and by select in the same vector. At this depth, reads show a pin change on exactly the second edge, so the latency can be checked to the cycle. It also shows a stale value after only one edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DATA  = 3'd0,
        OFS_SET   = 3'd1,
        OFS_CLR   = 3'd2,
        OFS_TOG   = 3'd3,
        OFS_DIR   = 3'd4,
        OFS_FSEL  = 3'd5
    } reg_ofs_e;

    typedef struct packed {
        logic wr_data;
        logic wr_set;
        logic wr_clr;
        logic wr_tog;
        logic wr_dir;
        logic wr_fsel;
    } wr_strb_t;

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] pin_sync,
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [NUM_PINS-1:0] fsel_q,
    output wr_strb_t            strb,
    output logic [NUM_PINS-1:0] bus_rdata
);

    logic do_wr;
    logic do_rd;

    assign do_wr = bus_sel & bus_we;
    assign do_rd = bus_sel & ~bus_we;

    // Write strobes: one-hot at most, unmapped offsets produce none
    always_comb begin
        strb = '0;
        if (do_wr) begin
            case (bus_addr)
                OFS_DATA: strb.wr_data = 1'b1;
                OFS_SET:  strb.wr_set  = 1'b1;
                OFS_CLR:  strb.wr_clr  = 1'b1;
                OFS_TOG:  strb.wr_tog  = 1'b1;
                OFS_DIR:  strb.wr_dir  = 1'b1;
                OFS_FSEL: strb.wr_fsel = 1'b1;
                default:  strb         = '0;
            endcase
        end
    end

    // Read mux: data returns synchronized pins; set/clear/toggle read zero
    always_comb begin
        bus_rdata = '0;
        if (do_rd) begin
            case (bus_addr)
                OFS_DATA: bus_rdata = pin_sync;
                OFS_DIR:  bus_rdata = dir_q;
                OFS_FSEL: bus_rdata = fsel_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  wr_strb_t            strb,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] latch_q
);

    typedef struct packed {
        logic [NUM_PINS-1:0] lat;
    } lat_state_t;

    lat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strb.wr_data) begin
            st_d.lat = wdata;
        end else if (strb.wr_set) begin
            st_d.lat = st_q.lat | wdata;
        end else if (strb.wr_clr) begin
            st_d.lat = st_q.lat & ~wdata;
        end else if (strb.wr_tog) begin
            st_d.lat = st_q.lat ^ wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_q = st_q.lat;

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  wr_strb_t            strb,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] fsel_q,
    output logic [NUM_PINS-1:0] oe
);

    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] fsel;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (strb.wr_dir) begin
            cfg_d.dir = wdata;
        end
        if (strb.wr_fsel) begin
            cfg_d.fsel = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign dir_q  = cfg_q.dir;
    assign fsel_q = cfg_q.fsel;

    // Drive only when the general-purpose function is selected and direction is output
    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_oe
            assign oe[i] = cfg_q.dir[i] & ~cfg_q.fsel[i];
        end
    endgenerate

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_sync
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [NUM_PINS-1:0] stage_d [SYNC_STAGES];
    logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = pin_in;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else begin
                    stage_q[s] <= stage_d[s];
                end
            end
        end
    endgenerate

    assign pin_sync = stage_q[LAST];

endmodule

// File: rtl/gpio_data_port.sv
module gpio_data_port
    import gpio_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    wr_strb_t            strb;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] fsel_q;
    logic [NUM_PINS-1:0] latch_q;

    gpio_bus_decode #(.NUM_PINS(NUM_PINS)) u_decode (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .pin_sync  (pin_sync),
        .dir_q     (dir_q),
        .fsel_q    (fsel_q),
        .strb      (strb),
        .bus_rdata (bus_rdata)
    );

    gpio_out_latch #(.NUM_PINS(NUM_PINS)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .strb    (strb),
        .wdata   (bus_wdata),
        .latch_q (latch_q)
    );

    gpio_cfg_regs #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb   (strb),
        .wdata  (bus_wdata),
        .dir_q  (dir_q),
        .fsel_q (fsel_q),
        .oe     (pin_oe)
    );

    gpio_in_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    assign pin_out = latch_q;

endmodule

// File: rtl/gpio_data_port_chk.sv
module gpio_data_port_chk
    import gpio_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] bus_wdata,
    input logic [NUM_PINS-1:0] bus_rdata,
    input logic [NUM_PINS-1:0] pin_in,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe
);

    logic [1:0] age_q;
    logic       wr_any;
    logic       rd_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assign wr_any = bus_sel & bus_we;
    assign rd_any = bus_sel & ~bus_we;

    AST_RESET_QUIET: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> (pin_out == '0 && pin_oe == '0)); // R1

    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == OFS_DATA) |=> (pin_out == $past(bus_wdata))); // R2

    AST_OE_WITHIN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == OFS_DIR) |=> ((pin_oe & ~$past(bus_wdata)) == '0)); // R3

    AST_OE_FSEL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == OFS_FSEL) |=> ((pin_oe & $past(bus_wdata)) == '0)); // R3

    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == OFS_SET) |=>
        (pin_out == ($past(pin_out) | $past(bus_wdata)))); // R5

    AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == OFS_CLR) |=>
        (pin_out == ($past(pin_out) & ~$past(bus_wdata)))); // R6

    AST_TOG_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == OFS_TOG) |=>
        ((pin_out ^ $past(pin_out)) == $past(bus_wdata))); // R7

    generate
        if (SYNC_STAGES == 2) begin : g_sync_chk
            AST_READ_SYNCED: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q >= 2'd2 && rd_any && bus_addr == OFS_DATA) |->
                (bus_rdata == $past(pin_in, 2))); // R8
        end
    endgenerate

    AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_any || bus_addr inside {OFS_SET, OFS_CLR, OFS_TOG, 3'd6, 3'd7}) |->
        (bus_rdata == '0)); // R9

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_any && bus_addr inside {OFS_DATA, OFS_SET, OFS_CLR, OFS_TOG}) |=>
        $stable(pin_out)); // R11

endmodule

bind gpio_data_port gpio_data_port_chk #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (.*);

// File: tb/gpio_data_port_tb.sv
module gpio_data_port_tb;

    localparam int NP = 32;
    localparam logic [NP-1:0] PIN_PAT = 32'hA5A5_0F0F;

    typedef struct packed {
        logic          we;
        logic [2:0]    addr;
        logic [NP-1:0] data;
        logic [NP-1:0] exp_out;
        logic [NP-1:0] exp_oe;
        logic [NP-1:0] exp_rd;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R2: data write loads latch, pins stay undriven
        '{1'b1, 3'd0, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000, 32'h0},
        // R8: data read returns pins, not latch
        '{1'b0, 3'd0, 32'h0,         32'h1234_5678, 32'h0000_0000, PIN_PAT},
        // R3: direction output upper half
        '{1'b1, 3'd4, 32'hFFFF_0000, 32'h1234_5678, 32'hFFFF_0000, 32'h0},
        // R3: function select removes drive
        '{1'b1, 3'd5, 32'h0F00_0000, 32'h1234_5678, 32'hF0FF_0000, 32'h0},
        // R5: set
        '{1'b1, 3'd1, 32'h0000_00FF, 32'h1234_56FF, 32'hF0FF_0000, 32'h0},
        // R6: clear
        '{1'b1, 3'd2, 32'h1200_0000, 32'h0034_56FF, 32'hF0FF_0000, 32'h0},
        // R7: toggle
        '{1'b1, 3'd3, 32'hFFFF_0000, 32'hFFCB_56FF, 32'hF0FF_0000, 32'h0},
        // R9: set register reads zero
        '{1'b0, 3'd1, 32'h0,         32'hFFCB_56FF, 32'hF0FF_0000, 32'h0},
        // R10: direction read back
        '{1'b0, 3'd4, 32'h0,         32'hFFCB_56FF, 32'hF0FF_0000, 32'hFFFF_0000},
        // R10: select read back
        '{1'b0, 3'd5, 32'h0,         32'hFFCB_56FF, 32'hF0FF_0000, 32'h0F00_0000},
        // R9: unmapped write ignored
        '{1'b1, 3'd6, 32'hFFFF_FFFF, 32'hFFCB_56FF, 32'hF0FF_0000, 32'h0},
        // R9: unmapped read zero
        '{1'b0, 3'd7, 32'h0,         32'hFFCB_56FF, 32'hF0FF_0000, 32'h0},
        // R4: stored level now driven
        '{1'b1, 3'd5, 32'h0000_0000, 32'hFFCB_56FF, 32'hFFFF_0000, 32'h0},
        // R8: pins unaffected by latch/config
        '{1'b0, 3'd0, 32'h0,         32'hFFCB_56FF, 32'hFFFF_0000, PIN_PAT}
    };

    logic          clk;
    logic          rst_n;
    logic          bus_sel;
    logic          bus_we;
    logic [2:0]    bus_addr;
    logic [NP-1:0] bus_wdata;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int n_chk;
    int n_bad;
    bit done;

    gpio_data_port #(.NUM_PINS(NP), .SYNC_STAGES(2)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check(input string req, input logic [NP-1:0] got, input logic [NP-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_idle();
        bus_sel   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
    endtask

    // Read at a negedge: rdata is combinational within the access cycle
    task automatic bus_read(input logic [2:0] a, output logic [NP-1:0] d);
        bus_sel  = 1'b1;
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_idle();
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [NP-1:0] d);
        bus_sel   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] rd;
        n_chk = 0;
        n_bad = 0;
        done  = 1'b0;
        rst_n = 1'b0;
        pin_in = PIN_PAT;
        bus_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 pin_out in reset", pin_out, '0);
        check("R1 pin_oe in reset", pin_oe, '0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(3'd4, rd);
        check("R1 dir after reset", rd, '0);
        bus_read(3'd5, rd);
        check("R1 fsel after reset", rd, '0);
        repeat (2) @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            bus_sel   = 1'b1;
            bus_we    = VECS[i].we;
            bus_addr  = VECS[i].addr;
            bus_wdata = VECS[i].data;
            #1;
            if (!VECS[i].we) check($sformatf("vec %0d read (R8/R9/R10)", i), bus_rdata, VECS[i].exp_rd);
            @(posedge clk);
            @(negedge clk);
            bus_idle();
            check($sformatf("vec %0d pin_out (R2/R4-R7)", i), pin_out, VECS[i].exp_out);
            check($sformatf("vec %0d pin_oe (R3/R4)", i), pin_oe, VECS[i].exp_oe);
        end

        // R11: write-enable low and select low leave latch untouched
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 3'd0; bus_wdata = 32'h0BAD_F00D;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = 32'hFFFF_FFFF;
        @(posedge clk); @(negedge clk);
        bus_idle();
        check("R11 latch hold", pin_out, 32'hFFCB_56FF);

        // R4: data write while pin undriven, then enable
        bus_write(3'd4, 32'h0000_0000);
        check("R4 oe off", pin_oe, '0);
        bus_write(3'd0, 32'h0000_00F0);
        check("R4 latch stored undriven", pin_out, 32'h0000_00F0);
        bus_write(3'd4, 32'h0000_00FF);
        check("R4 level driven", pin_out & pin_oe, 32'h0000_00F0);

        // R8: two-edge latency of pin change
        pin_in = 32'h1357_9BDF;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 3'd0;
        #1;
        check("R8 one edge still old", bus_rdata, PIN_PAT);
        @(posedge clk); @(negedge clk);
        #1;
        check("R8 two edges new", bus_rdata, 32'h1357_9BDF);
        bus_idle();
        #1;
        check("R9 idle reads zero", bus_rdata, '0);

        // R1: reset mid-run clears latch and config
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 latch cleared", pin_out, '0);
        check("R1 oe cleared", pin_oe, '0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule